// File: doc/BRIEF.md
# Prioritized Interrupt Masking Controller

This block gathers interrupt requests from three classes, arbitrates among them and presents a single deliverable interrupt per cycle. The classes are an initialization request, a performance-monitor request and a bank of external request lines, one line per 8-bit vector. Each source has a pending bit. External vectors that software has acknowledged move into an in-service set that nests by priority.

Two separate conditions decide whether an interrupt is delivered. Masking applies only to external vectors. It compares the highest pending vector against the highest in-service vector and against a task-priority threshold. Delivery enables are three processor status inputs, one per class. The external enable gates only delivery, so the unmasked-vector outputs stay meaningful while that enable is off. Software acknowledges the highest unmasked external vector to move it into service, and signals end of service to retire the highest in-service vector. Both actions take effect at the next clock edge.

All outputs are registered. They reflect the internal state and the control inputs as they stood during the previous cycle.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every pending bit and in-service bit clears and every output reads 0.
- R2: The initialization request (class code 1 on `irq_class`, `irq_vector` 0) is delivered only while `st_mchk` is 0.
- R3: The performance-monitor request (class code 2, `irq_vector` 0) is delivered only while `st_coll` is 1.
- R4: An external interrupt (class code 3, `irq_vector` = its vector) is delivered only when it is unmasked and `st_ien` is 1. Class code 0 with `irq_valid` low means nothing is deliverable.
- R5: Fixed priority is initialization over performance-monitor over external. The highest deliverable source wins, so a pending but blocked higher class never hides a deliverable lower class.
- R6: Let v be the highest pending external vector, where a larger number means higher priority. v is unmasked only when all three hold: `tpr_mask_all` is 0, v[7:4] is strictly greater than `tpr_class`, and v is strictly greater than the highest in-service vector (if any). `ext_unmasked`/`ext_vector` then report v. Otherwise both read 0.
- R7: `st_ien` has no effect on `ext_unmasked` or `ext_vector`.
- R8: A high bit of `ext_req` sets that vector's pending bit. A repeat request while it is pending merges into the same bit, so a single acknowledge removes it.
- R9: `ack` clears the pending bit of the current highest unmasked vector and marks it in service. When no vector is unmasked, `ack` changes nothing. A new request for the same vector in the acknowledge cycle leaves it pending.
- R10: `eoi` clears only the highest in-service vector. Lower in-service vectors remain and are then reported on `isr_valid`/`isr_vector`.
- R11: `init_req`/`perf_req` set their pending bit, and `init_done`/`perf_done` clear it. A request in the same cycle as a done keeps the bit set.
- R12: Every output at edge k+1 is a function of the state and inputs present just before edge k+1. A request at edge k therefore first appears on the outputs at edge k+1 after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 256 | External request lines, bit n requests vector n |
| init_req | input | 1 | Initialization request |
| perf_req | input | 1 | Performance-monitor request |
| init_done | input | 1 | Clears the initialization pending bit |
| perf_done | input | 1 | Clears the performance-monitor pending bit |
| st_mchk | input | 1 | Machine-check status bit, blocks initialization delivery when 1 |
| st_coll | input | 1 | Interruption-collection status bit, enables performance-monitor delivery |
| st_ien | input | 1 | Interrupt-enable status bit, enables external delivery |
| tpr_mask_all | input | 1 | Masks every external vector |
| tpr_class | input | 4 | Priority-class threshold |
| ack | input | 1 | Acknowledge highest unmasked external vector |
| eoi | input | 1 | End of service for highest in-service vector |
| irq_valid | output | 1 | A deliverable interrupt is presented |
| irq_class | output | 2 | 0 none, 1 initialization, 2 performance-monitor, 3 external |
| irq_vector | output | 8 | Vector of the delivered external interrupt, else 0 |
| ext_unmasked | output | 1 | An unmasked external vector exists |
| ext_vector | output | 8 | Highest unmasked external vector, else 0 |
| isr_valid | output | 1 | Some vector is in service |
| isr_vector | output | 8 | Highest in-service vector, else 0 |

## Verification
The assertions assume that every input is driven to a known value in each cycle after reset. They also assume that `tpr_class` and the status bits are sampled once per edge. Against those sampled values they check the one-cycle-lagged class gating, threshold and in-service ordering.

The stimulus changes inputs only at the falling clock edge and holds them steady through the rising edge. It issues `ack` and `eoi` freely, including when nothing is unmasked or in service. This means the ignored-request paths are part of the legal input space rather than excluded from it.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_INIT = 2'd1,
    CLS_PERF = 2'd2,
    CLS_EXT  = 2'd3
  } irq_cls_e;

  localparam int CLS_W = 2;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     set_bits,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     pend
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          pend[g] <= 1'b0;
        else if (set_bits[g])
          pend[g] <= 1'b1;
        else if (clr_en && (clr_idx == IDX_W'(g)))
          pend[g] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             top_found,
  output logic [IDX_W-1:0] top_idx
);

  logic [N-1:0] svc;

  irq_prio_enc #(.N(N), .IDX_W(IDX_W)) u_top (
    .bits  (svc),
    .found (top_found),
    .idx   (top_idx)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          svc[g] <= 1'b0;
        else if (push && (push_idx == IDX_W'(g)))
          svc[g] <= 1'b1;
        else if (pop && top_found && (top_idx == IDX_W'(g)))
          svc[g] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [(1<<VEC_W)-1:0] ext_req,
  input  logic                 init_req,
  input  logic                 perf_req,
  input  logic                 init_done,
  input  logic                 perf_done,
  input  logic                 st_mchk,
  input  logic                 st_coll,
  input  logic                 st_ien,
  input  logic                 tpr_mask_all,
  input  logic [CLASS_W-1:0]   tpr_class,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 irq_valid,
  output logic [1:0]           irq_class,
  output logic [VEC_W-1:0]     irq_vector,
  output logic                 ext_unmasked,
  output logic [VEC_W-1:0]     ext_vector,
  output logic                 isr_valid,
  output logic [VEC_W-1:0]     isr_vector
);
  import irq_mask_pkg::*;

  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] ext_pend;
  logic               hp_found;
  logic [VEC_W-1:0]   hp_idx;
  logic               svc_found;
  logic [VEC_W-1:0]   svc_idx;
  logic               unm;
  logic               ack_fire;
  logic               init_pend, perf_pend;
  irq_cls_e           cls_d;

  irq_prio_enc #(.N(NUM_VEC), .IDX_W(VEC_W)) u_hp (
    .bits  (ext_pend),
    .found (hp_found),
    .idx   (hp_idx)
  );

  // masking: threshold, mask-all and in-service ordering; status bits take no part
  always_comb begin
    unm = hp_found && !tpr_mask_all &&
          (hp_idx[VEC_W-1 -: CLASS_W] > tpr_class) &&
          (!svc_found || (hp_idx > svc_idx));
  end

  assign ack_fire = ack && unm;

  irq_pend_bank #(.N(NUM_VEC), .IDX_W(VEC_W)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_bits (ext_req),
    .clr_en   (ack_fire),
    .clr_idx  (hp_idx),
    .pend     (ext_pend)
  );

  irq_isr_stack #(.N(NUM_VEC), .IDX_W(VEC_W)) u_isr (
    .clk       (clk),
    .rst       (rst),
    .push      (ack_fire),
    .push_idx  (hp_idx),
    .pop       (eoi),
    .top_found (svc_found),
    .top_idx   (svc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_pend <= 1'b0;
      perf_pend <= 1'b0;
    end else begin
      init_pend <= init_req | (init_pend & ~init_done);
      perf_pend <= perf_req | (perf_pend & ~perf_done);
    end
  end

  // delivery: fixed order, each class gated by its own status bit
  always_comb begin
    if (init_pend && !st_mchk)
      cls_d = CLS_INIT;
    else if (perf_pend && st_coll)
      cls_d = CLS_PERF;
    else if (unm && st_ien)
      cls_d = CLS_EXT;
    else
      cls_d = CLS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid    <= 1'b0;
      irq_class    <= 2'd0;
      irq_vector   <= '0;
      ext_unmasked <= 1'b0;
      ext_vector   <= '0;
      isr_valid    <= 1'b0;
      isr_vector   <= '0;
    end else begin
      irq_valid    <= (cls_d != CLS_NONE);
      irq_class    <= cls_d;
      irq_vector   <= (cls_d == CLS_EXT) ? hp_idx : '0;
      ext_unmasked <= unm;
      ext_vector   <= unm ? hp_idx : '0;
      isr_valid    <= svc_found;
      isr_vector   <= svc_found ? svc_idx : '0;
    end
  end

endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               st_mchk,
  input logic               st_coll,
  input logic               st_ien,
  input logic               tpr_mask_all,
  input logic [CLASS_W-1:0] tpr_class,
  input logic               irq_valid,
  input logic [1:0]         irq_class,
  input logic [VEC_W-1:0]   irq_vector,
  input logic               ext_unmasked,
  input logic [VEC_W-1:0]   ext_vector,
  input logic               isr_valid,
  input logic [VEC_W-1:0]   isr_vector
);

  AST_INIT_GATE: assert property (@(posedge clk) disable iff (rst)
    (irq_class == 2'd1) |-> !$past(st_mchk)); // R2

  AST_PERF_GATE: assert property (@(posedge clk) disable iff (rst)
    (irq_class == 2'd2) |-> $past(st_coll)); // R3

  AST_EXT_GATE: assert property (@(posedge clk) disable iff (rst)
    (irq_class == 2'd3) |-> ($past(st_ien) && ext_unmasked && (irq_vector == ext_vector))); // R4

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
    $past(tpr_mask_all) |-> !ext_unmasked); // R6

  AST_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    ext_unmasked |-> (ext_vector[VEC_W-1 -: CLASS_W] > $past(tpr_class))); // R6

  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ext_unmasked && isr_valid) |-> (ext_vector > isr_vector)); // R6

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_class == 2'd0 && irq_vector == '0)); // R4

endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st_mchk      (st_mchk),
  .st_coll      (st_coll),
  .st_ien       (st_ien),
  .tpr_mask_all (tpr_mask_all),
  .tpr_class    (tpr_class),
  .irq_valid    (irq_valid),
  .irq_class    (irq_class),
  .irq_vector   (irq_vector),
  .ext_unmasked (ext_unmasked),
  .ext_vector   (ext_vector),
  .isr_valid    (isr_valid),
  .isr_vector   (isr_vector)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  localparam int VW = 8;
  localparam int CW = 4;
  localparam int NV = 1 << VW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [NV-1:0] ext_req;
  logic          init_req, perf_req, init_done, perf_done;
  logic          st_mchk, st_coll, st_ien, tpr_mask_all;
  logic [CW-1:0] tpr_class;
  logic          ack, eoi;
  logic          irq_valid, ext_unmasked, isr_valid;
  logic [1:0]    irq_class;
  logic [VW-1:0] irq_vector, ext_vector, isr_vector;

  irq_mask_ctrl #(.VEC_W(VW), .CLASS_W(CW)) u_irq_mask_ctrl (
    .clk(clk), .rst(rst), .ext_req(ext_req),
    .init_req(init_req), .perf_req(perf_req),
    .init_done(init_done), .perf_done(perf_done),
    .st_mchk(st_mchk), .st_coll(st_coll), .st_ien(st_ien),
    .tpr_mask_all(tpr_mask_all), .tpr_class(tpr_class),
    .ack(ack), .eoi(eoi),
    .irq_valid(irq_valid), .irq_class(irq_class), .irq_vector(irq_vector),
    .ext_unmasked(ext_unmasked), .ext_vector(ext_vector),
    .isr_valid(isr_valid), .isr_vector(isr_vector)
  );

  int checks = 0;
  int fails  = 0;

  logic [NV-1:0] m_pend, m_isr;
  logic          m_init, m_perf;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int top_of(logic [NV-1:0] v);
    int r = -1;
    for (int i = 0; i < NV; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic quiet();
    ext_req = '0; init_req = 0; perf_req = 0; init_done = 0; perf_done = 0;
    ack = 0; eoi = 0;
  endtask

  // one clock: expected outputs from model state and held inputs, then advance model
  task automatic step(string tag);
    int hp, hs;
    bit unm;
    logic [1:0] ecls;
    logic [VW-1:0] evec;
    logic [NV-1:0] pn, sn;
    hp = top_of(m_pend);
    hs = top_of(m_isr);
    unm = (hp >= 0) && !tpr_mask_all && ((hp >> (VW-CW)) > int'(tpr_class)) &&
          ((hs < 0) || (hp > hs));
    if (m_init && !st_mchk)      ecls = 2'd1;
    else if (m_perf && st_coll)  ecls = 2'd2;
    else if (unm && st_ien)      ecls = 2'd3;
    else                         ecls = 2'd0;
    evec = (ecls == 2'd3) ? VW'(hp) : '0;
    pn = m_pend; sn = m_isr;
    if (eoi && hs >= 0) sn[hs] = 1'b0;
    if (ack && unm) begin pn[hp] = 1'b0; sn[hp] = 1'b1; end
    pn = pn | ext_req;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "irq", {21'd0, irq_valid, irq_class, irq_vector}, {21'd0, ecls != 2'd0, ecls, evec});
    chk(tag, "unmasked", {23'd0, ext_unmasked, ext_vector}, {23'd0, unm, unm ? VW'(hp) : VW'(0)});
    chk(tag, "in-service", {23'd0, isr_valid, isr_vector}, {23'd0, hs >= 0, (hs >= 0) ? VW'(hs) : VW'(0)});
    m_init = init_req | (m_init & ~init_done);
    m_perf = perf_req | (m_perf & ~perf_done);
    m_pend = pn; m_isr = sn;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    quiet();
    st_mchk = 0; st_coll = 0; st_ien = 0; tpr_mask_all = 0; tpr_class = '0;
    rst = 1;
    ext_req[200] = 1'b1; init_req = 1; ack = 1;
    repeat (3) @(negedge clk);
    // R1: reset state at outputs
    chk("R1", "irq", {21'd0, irq_valid, irq_class, irq_vector}, 32'd0);
    chk("R1", "unmasked", {23'd0, ext_unmasked, ext_vector}, 32'd0);
    chk("R1", "in-service", {23'd0, isr_valid, isr_vector}, 32'd0);
    m_pend = '0; m_isr = '0; m_init = 0; m_perf = 0;
    quiet();
    rst = 0;
    step("R1");

    // R2: init blocked by machine-check bit, then delivered
    st_mchk = 1; init_req = 1; step("R2");
    quiet(); step("R2"); step("R2");
    st_mchk = 0; step("R2");
    // R11: request wins over done in the same cycle, then done clears
    init_req = 1; init_done = 1; step("R11");
    quiet(); step("R11");
    init_done = 1; step("R11");
    quiet(); step("R11");

    // R3 and R5: perf gated by collection bit; blocked init does not hide perf
    perf_req = 1; st_mchk = 1; init_req = 1; step("R3");
    quiet(); step("R3");
    st_coll = 1; step("R5"); step("R5");
    st_mchk = 0; step("R5");
    init_done = 1; perf_done = 1; step("R5");
    quiet(); step("R5");

    // R6/R7: threshold on upper nibble, strictly greater
    tpr_class = 4'd3; ext_req[8'h35] = 1'b1; step("R6");
    quiet(); step("R6");
    tpr_class = 4'd2; step("R6");
    st_ien = 0; step("R7"); step("R7");
    tpr_mask_all = 1; step("R6"); step("R6");
    tpr_mask_all = 0; st_ien = 1; step("R4"); step("R12");

    // R8: repeated request merges; one acknowledge drains it
    ext_req[8'h35] = 1'b1; step("R8");
    quiet(); ack = 1; step("R8");
    quiet(); step("R8"); step("R8");
    // R9: ack with nothing unmasked is ignored
    ack = 1; step("R9");
    quiet(); step("R9");
    // R10: nesting and end of service
    ext_req[8'h40] = 1'b1; ext_req[8'h30] = 1'b1; step("R10");
    quiet(); step("R10");
    ack = 1; step("R9");
    quiet(); step("R10");
    ext_req[8'h60] = 1'b1; step("R10");
    quiet(); step("R10");
    ack = 1; ext_req[8'h60] = 1'b1; step("R9");
    quiet(); step("R9");
    ack = 1; step("R9");
    quiet(); step("R10");
    eoi = 1; step("R10");
    quiet(); step("R10");
    eoi = 1; step("R10");
    eoi = 1; step("R10");
    eoi = 1; step("R10");
    quiet(); step("R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      quiet();
      if ($urandom % 3 == 0) ext_req[$urandom % NV] = 1'b1;
      if ($urandom % 8 == 0) ext_req[128 + ($urandom % 128)] = 1'b1;
      init_req  = ($urandom % 20) == 0;
      perf_req  = ($urandom % 16) == 0;
      init_done = ($urandom % 6) == 0;
      perf_done = ($urandom % 6) == 0;
      st_mchk   = ($urandom % 3) == 0;
      st_coll   = ($urandom % 3) != 0;
      st_ien    = ($urandom % 4) != 0;
      tpr_mask_all = ($urandom % 16) == 0;
      tpr_class = CW'($urandom % 8);
      ack = ($urandom % 3) == 0;
      eoi = ($urandom % 6) == 0;
      step("R5");
    end
    quiet();
    step("R12");
    finish_run();
  end

endmodule